// File: doc/BRIEF.md
# Proximity-Card Subcarrier Load Modulator

This block turns a 13.56 MHz carrier clock into the card-to-reader answer signal of a proximity card. It divides the carrier down to an 847.5 kHz subcarrier (one sixteenth) and to a bit rate of about 105.9 kHz (one 128th), so each bit spans exactly eight subcarrier periods. It then keys the subcarrier with one data bit per bit period and drives the gate of an open-collector load switch.

Two modulation schemes are offered. In the first, the bits are Manchester coded and the subcarrier is switched on and off (ASK). In the second, the bits are NRZ coded and the subcarrier phase is flipped (BPSK). Each bit comes from one of three sources: an endless run of ones, an endless alternation of one and zero, or a serial input that the block samples once per bit while it raises a request strobe. The scheme and source selects may change at any time. They take effect only at the next bit boundary, so a bit is never cut short or mixed between schemes.

A small source state machine holds the source in use. Its states are ONES, ALT_HI, ALT_LO and EXT. At each bit boundary it goes to ONES when the select reads 00 or 11, and to EXT when the select reads 10. With select 01 it goes from ALT_HI to ALT_LO, from ALT_LO to ALT_HI, and from any other state to ALT_HI. Between boundaries it holds its state. The modulator has two states, ASK_MAN and BPSK_NRZ, which are reloaded from the scheme select at each boundary.

Top module: `card_subcarrier_mod`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `load_sw` and `ext_strobe` are 0. Reset leaves the divider count at 0, the scheme at ASK/Manchester and the source at all-ones.
- R2: The subcarrier is bit 3 of a free-running count that starts at 0 after reset. It is low for 8 carrier cycles and then high for 8, with a period of 16 cycles.
- R3: A bit lasts 128 carrier cycles. `ext_strobe` is high in exactly the last cycle of each bit, where the count is 127.
- R4: With ASK/Manchester (`mode_sel` = 0), a 1 bit lets the subcarrier through in cycles 0 to 63 of the bit and holds `load_sw` at 0 in cycles 64 to 127. A 0 bit does the reverse.
- R5: With BPSK/NRZ (`mode_sel` = 1), `load_sw` equals the subcarrier during a 1 bit and its inverse during a 0 bit.
- R6: `mode_sel` is sampled only on the clock edge that ends a bit. A change at any other time has no effect on `load_sw` until the next bit begins.
- R7: `src_sel` is sampled only at the bit-ending edge. 00 and 11 give all ones. 01 gives alternating bits, starting with 1 in the first bit after alternation is selected. 10 gives the serial input.
- R8: With the serial source, `ext_data` is sampled on the edge that ends the strobe cycle. The sampled value becomes the bit sent in the following bit period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Carrier clock, 13.56 MHz |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 1 | Scheme select: 0 ASK/Manchester, 1 BPSK/NRZ |
| src_sel | input | 2 | Data source select: 00/11 ones, 01 alternating, 10 serial |
| ext_data | input | 1 | Serial data bit from the external source |
| ext_strobe | output | 1 | High in the cycle in which `ext_data` is taken |
| load_sw | output | 1 | Gate drive for the open-collector load switch |

## Verification
The bound checker keeps its own count from reset. On every cycle it checks four things: the strobe lands only where its count reads 127, the latched scheme holds still away from a boundary, the switch stays off in the gated half of an ASK one bit, and the BPSK output follows the subcarrier XOR the inverted bit. The bench runs a cycle model, which is the only way to confirm that the alternating pattern restarts at 1, that serial data lands in the following bit, and that select changes made mid-bit are held back until the boundary. It drives directed runs of every scheme and source pair, then random select changes with random serial data.

// File: rtl/csm_pkg.sv
package csm_pkg;
    typedef enum logic {
        MOD_ASK_MAN  = 1'b0,
        MOD_BPSK_NRZ = 1'b1
    } mod_e;

    typedef enum logic [1:0] {
        SRC_ONES   = 2'd0,
        SRC_ALT_HI = 2'd1,
        SRC_ALT_LO = 2'd2,
        SRC_EXT    = 2'd3
    } src_state_e;

    localparam logic [1:0] SEL_ONES = 2'b00;
    localparam logic [1:0] SEL_ALT  = 2'b01;
    localparam logic [1:0] SEL_EXT  = 2'b10;
endpackage

// File: rtl/csm_divider.sv
module csm_divider #(
    parameter int SUB_LOG2 = 4,
    parameter int BIT_LOG2 = 7
) (
    input  logic clk,
    input  logic rst_n,
    output logic subcar,
    output logic late_half,
    output logic boundary
);
    logic [BIT_LOG2-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    assign subcar    = cnt_q[SUB_LOG2-1];
    assign late_half = cnt_q[BIT_LOG2-1];
    assign boundary  = &cnt_q;
endmodule

// File: rtl/csm_source.sv
module csm_source
    import csm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       boundary,
    input  logic [1:0] src_sel,
    input  logic       ext_data,
    output logic       data_bit
);
    src_state_e state_q, state_d;
    logic       ext_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SRC_ONES;
            ext_q   <= 1'b1;
        end else if (boundary) begin
            state_q <= state_d;
            ext_q   <= ext_data;
        end
    end

    always_comb begin
        state_d = SRC_ONES;
        unique case (src_sel)
            SEL_ALT: state_d = (state_q == SRC_ALT_HI) ? SRC_ALT_LO : SRC_ALT_HI;
            SEL_EXT: state_d = SRC_EXT;
            default: state_d = SRC_ONES;
        endcase
    end

    always_comb begin
        data_bit = 1'b1;
        unique case (state_q)
            SRC_ONES:   data_bit = 1'b1;
            SRC_ALT_HI: data_bit = 1'b1;
            SRC_ALT_LO: data_bit = 1'b0;
            SRC_EXT:    data_bit = ext_q;
        endcase
    end
endmodule

// File: rtl/csm_modulator.sv
module csm_modulator
    import csm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic boundary,
    input  logic mode_sel,
    input  logic subcar,
    input  logic late_half,
    input  logic data_bit,
    output logic mode_q,
    output logic load_sw
);
    mod_e mode_st;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        mode_st <= MOD_ASK_MAN;
        else if (boundary) mode_st <= mod_e'(mode_sel);
    end

    always_comb begin
        load_sw = 1'b0;
        unique case (mode_st)
            MOD_ASK_MAN:  load_sw = subcar & (data_bit ^ late_half);
            MOD_BPSK_NRZ: load_sw = subcar ^ ~data_bit;
        endcase
    end

    assign mode_q = mode_st;
endmodule

// File: rtl/card_subcarrier_mod.sv
module card_subcarrier_mod #(
    parameter int SUB_LOG2 = 4,
    parameter int BIT_LOG2 = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_sel,
    input  logic [1:0] src_sel,
    input  logic       ext_data,
    output logic       ext_strobe,
    output logic       load_sw
);
    logic subcar;
    logic late_half;
    logic boundary;
    logic cur_bit;
    logic mod_mode;

    csm_divider #(.SUB_LOG2(SUB_LOG2), .BIT_LOG2(BIT_LOG2)) u_div (
        .clk(clk), .rst_n(rst_n),
        .subcar(subcar), .late_half(late_half), .boundary(boundary)
    );

    csm_source u_src (
        .clk(clk), .rst_n(rst_n), .boundary(boundary),
        .src_sel(src_sel), .ext_data(ext_data), .data_bit(cur_bit)
    );

    csm_modulator u_mod (
        .clk(clk), .rst_n(rst_n), .boundary(boundary),
        .mode_sel(mode_sel), .subcar(subcar), .late_half(late_half),
        .data_bit(cur_bit), .mode_q(mod_mode), .load_sw(load_sw)
    );

    assign ext_strobe = boundary;
endmodule

// File: rtl/csm_checker.sv
module csm_checker #(
    parameter int SUB_LOG2 = 4,
    parameter int BIT_LOG2 = 7
) (
    input logic clk,
    input logic rst_n,
    input logic ext_strobe,
    input logic load_sw,
    input logic mode_q,
    input logic bit_q
);
    localparam logic [BIT_LOG2-1:0] LAST = '1;
    logic [BIT_LOG2-1:0] cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc <= '0;
        else        cyc <= cyc + 1'b1;
    end

    // R3: strobe only in the last cycle of the bit
    a_r3_strobe_place: assert property (@(posedge clk) disable iff (!rst_n)
        ext_strobe == (cyc == LAST));

    // R6: scheme holds away from a bit boundary
    a_r6_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_strobe |=> $stable(mode_q));

    // R4: ASK one bit is silent in the second half
    a_r4_ask_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && bit_q && cyc[BIT_LOG2-1]) |-> !load_sw);

    // R5: BPSK follows subcarrier, inverted on a zero bit
    a_r5_bpsk_phase: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q |-> (load_sw == (cyc[SUB_LOG2-1] ^ !bit_q)));
endmodule

bind card_subcarrier_mod csm_checker #(.SUB_LOG2(SUB_LOG2), .BIT_LOG2(BIT_LOG2)) u_chk (
    .clk(clk), .rst_n(rst_n), .ext_strobe(ext_strobe),
    .load_sw(load_sw), .mode_q(mod_mode), .bit_q(cur_bit)
);

// File: tb/tb_card_subcarrier_mod.sv
module tb_card_subcarrier_mod;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_sel = 1'b0;
    logic [1:0] src_sel = 2'b00;
    logic       ext_data = 1'b0;
    logic       ext_strobe;
    logic       load_sw;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    card_subcarrier_mod dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .src_sel(src_sel),
        .ext_data(ext_data), .ext_strobe(ext_strobe), .load_sw(load_sw)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model built from R2, R3, R6, R7, R8
    logic [6:0] m_cnt;
    logic       m_mode;
    int         m_state;   // 0 ones, 1 alt high, 2 alt low, 3 serial
    logic       m_ext;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt <= 7'd0; m_mode <= 1'b0; m_state <= 0; m_ext <= 1'b1;
        end else begin
            m_cnt <= m_cnt + 7'd1;
            if (m_cnt == 7'd127) begin
                m_mode <= mode_sel;
                m_ext  <= ext_data;
                case (src_sel)
                    2'b01:   m_state <= (m_state == 1) ? 2 : 1;
                    2'b10:   m_state <= 3;
                    default: m_state <= 0;
                endcase
            end
        end
    end

    function automatic logic model_bit(int st, logic ex);
        case (st)
            2:       return 1'b0;
            3:       return ex;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic model_sw(logic [6:0] c, logic md, logic b);
        logic sc;
        sc = c[3];
        if (md) return sc ^ !b;
        return sc & (b ? !c[6] : c[6]);
    endfunction

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                check("R1 reset load_sw", load_sw, 1'b0);
                check("R1 reset strobe", ext_strobe, 1'b0);
            end else begin
                check("R3 strobe", ext_strobe, m_cnt == 7'd127);
                if (m_mode)
                    check("R5 R2 R6 R7 R8 bpsk", load_sw,
                          model_sw(m_cnt, m_mode, model_bit(m_state, m_ext)));
                else
                    check("R4 R2 R6 R7 R8 ask", load_sw,
                          model_sw(m_cnt, m_mode, model_bit(m_state, m_ext)));
            end
        end
    end

    task automatic run(int n, bit rnd_ext);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rnd_ext) ext_data = $urandom_range(0, 1);
        end
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: first cycle after reset
        @(negedge clk);
        check("R1 first cycle", load_sw, 1'b0);
        // directed: every scheme with every source, selects changed mid-bit
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                mode_sel = m[0];
                src_sel  = s[1:0];
                run(700, s == 2);
            end
        end
        // R8 corner: serial value flips right at the strobe cycle
        src_sel = 2'b10;
        mode_sel = 1'b1;
        for (int k = 0; k < 6; k++) begin
            while (ext_strobe !== 1'b1) @(negedge clk);
            ext_data = k[0];
            @(negedge clk);
            ext_data = ~k[0];
        end
        // random select changes at arbitrary cycles
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            ext_data = $urandom_range(0, 1);
            if ($urandom_range(0, 40) == 0) mode_sel = $urandom_range(0, 1);
            if ($urandom_range(0, 40) == 0) src_sel  = $urandom_range(0, 3);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule